// File: doc/BRIEF.md
# Paged Phased Current-Sense Gain Register Bank

This block stores one current-sense gain word for each phase of two output channels. It also stores one more word per channel that applies to the channel's summed phase current. A slave front end presents word-wide commands to the block. The block decides which stored entries a read or write reaches from two selector bytes, a page selector and a phase selector. Each of these selectors has a broadcast code, and the phase selector also has a code for the summed-current entry.

Every write is checked. The word must be word-sized, the value must lie in a fixed legal window, and the selectors must name existing entries. A failed check drops the write. It also sets a sticky communication-error flag, sets that flag's summary bit in the status word, and asserts an alert line. All three stay set until the host pulses a clear strobe. The phase count of each channel and the reset gain are parameters.

Top module: `calgain_bank`

## Requirements
- R1: After reset, every stored entry reads as the parameter default (D140h by default). The error flag, the summary bit and the alert are all 0.
- R2: A read strobe with `cmd_hit` high returns data on `rd_word` with `rd_valid` high in the cycle after the strobe. Page 00h selects channel A and page 01h selects channel B. Phase value n (below 80h) selects phase n+1.
- R3: A valid write with page FFh reaches the addressed entry in both channels. A channel that has no such phase is left unchanged.
- R4: A valid write with phase FFh reaches every per-phase entry of the selected channel or channels. It leaves the summed-current entry unchanged.
- R5: Phase 80h addresses a summed-current entry per channel, and this entry is separate from every per-phase entry.
- R6: Only word values from D131h to D150h inclusive are accepted. Bits 15:11 of any word read back are always 11010b.
- R7: A write whose value is outside the legal window leaves every entry unchanged. The same write sets `cml_err`, `sw_cml` and `alert` in the next cycle.
- R8: An access with `word_acc` low is invalid, whether it is a read or a write. The write is dropped, the flags are set, and a read returns 0000h.
- R9: A read with page FFh or phase FFh returns channel A phase 1 and raises no error.
- R10: A read or write of a phase index not below the channel's phase count is invalid. The same holds for a page value other than 00h, 01h or FFh. An invalid read returns 0000h and sets the flags.
- R11: The flags and the alert are sticky. A `clr_stb` pulse clears them in the next cycle, unless an invalid access occurs in the same cycle, in which case they stay set.
- R12: While `cmd_hit` is low, the read and write strobes have no effect. In that case there is no data, no change to the stored entries and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hit | input | 1 | Current command addresses this register |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| word_acc | input | 1 | 1 = word-sized access, 0 = byte-sized |
| page_sel | input | 8 | Page selector value |
| phase_sel | input | 8 | Phase selector value |
| wr_word | input | 16 | Write data |
| clr_stb | input | 1 | Clears the sticky flags and the alert |
| rd_word | output | 16 | Read data |
| rd_valid | output | 1 | Read data valid |
| cml_err | output | 1 | Communication-error flag |
| sw_cml | output | 1 | Status-word summary bit for that flag |
| alert | output | 1 | Alert to host |

## Verification
A wrongly steered write enable corrupts an entry without any visible sign at the time. That corruption only shows when the entry is read, which is one cycle after the read strobe. For this reason the bench reads every entry of both channels, including the summed-current entries, after each broadcast or selective write. A wrong validity decision shows in the flags one cycle after the access, so the flags are compared after every single operation. This also catches a stuck or prematurely cleared sticky bit at the first access that follows.

// File: rtl/calgain_pkg.sv
package calgain_pkg;
   localparam int WORD_W = 16;
   localparam int MAN_W  = 11;
   localparam int SEL_W  = 8;
   localparam logic [4:0]        GAIN_EXP = 5'b11010;
   localparam logic [WORD_W-1:0] GAIN_LO  = 16'hD131;
   localparam logic [WORD_W-1:0] GAIN_HI  = 16'hD150;
   localparam logic [SEL_W-1:0]  SEL_ALL  = 8'hFF;
   localparam logic [SEL_W-1:0]  PH_SUM   = 8'h80;
   localparam logic [SEL_W-1:0]  PG_CHA   = 8'h00;
   localparam logic [SEL_W-1:0]  PG_CHB   = 8'h01;

   function automatic logic gain_ok(input logic [WORD_W-1:0] w);
      return (w >= GAIN_LO) && (w <= GAIN_HI);
   endfunction
endpackage

// File: rtl/calgain_decode.sv
module calgain_decode
   import calgain_pkg::*;
#(
   parameter int NPH_A  = 6,
   parameter int NPH_B  = 2,
   parameter int SLOT_W = 3
) (
   input  logic              cmd_hit,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic              word_acc,
   input  logic [SEL_W-1:0]  page_sel,
   input  logic [SEL_W-1:0]  phase_sel,
   input  logic [WORD_W-1:0] wr_word,
   output logic              wr_commit,
   output logic              hit_a,
   output logic              hit_b,
   output logic              ph_all,
   output logic              ph_sum,
   output logic              rd_go,
   output logic              rd_ok,
   output logic              rd_ch,
   output logic [SLOT_W-1:0] rd_slot,
   output logic              bad_access
);
   localparam int MAXN = (NPH_A > NPH_B) ? NPH_A : NPH_B;

   logic wr_go, pg_a, pg_b, pg_all, pg_ok, idx_ok, wr_ok, rd_dflt;
   int   lim;

   always_comb begin
      wr_go   = cmd_hit & wr_stb;
      rd_go   = cmd_hit & rd_stb;
      pg_a    = (page_sel == PG_CHA);
      pg_b    = (page_sel == PG_CHB);
      pg_all  = (page_sel == SEL_ALL);
      pg_ok   = pg_a | pg_b | pg_all;
      ph_all  = (phase_sel == SEL_ALL);
      ph_sum  = (phase_sel == PH_SUM);
      lim     = pg_a ? NPH_A : (pg_b ? NPH_B : MAXN);
      idx_ok  = (phase_sel < PH_SUM) && (int'(phase_sel) < lim);
      wr_ok   = word_acc & gain_ok(wr_word) & pg_ok & (ph_all | ph_sum | idx_ok);
      rd_dflt = pg_all | ph_all;
      rd_ok   = word_acc & pg_ok & (rd_dflt | ph_sum | idx_ok);
      hit_a   = pg_a | pg_all;
      hit_b   = pg_b | pg_all;
      wr_commit  = wr_go & wr_ok;
      bad_access = (wr_go & ~wr_ok) | (rd_go & ~rd_ok);
      rd_ch   = pg_b & ~rd_dflt;
      if (rd_dflt)
         rd_slot = '0;
      else if (ph_sum)
         rd_slot = pg_b ? SLOT_W'(NPH_B) : SLOT_W'(NPH_A);
      else
         rd_slot = phase_sel[SLOT_W-1:0];
   end
endmodule

// File: rtl/calgain_store.sv
module calgain_store
   import calgain_pkg::*;
#(
   parameter int                NPH     = 6,
   parameter int                SLOT_W  = 3,
   parameter logic [MAN_W-1:0]  RST_MAN = 11'h140
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_commit,
   input  logic              ch_hit,
   input  logic              ph_all,
   input  logic              ph_sum,
   input  logic [SEL_W-1:0]  phase_sel,
   input  logic [MAN_W-1:0]  wr_man,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [MAN_W-1:0]  rd_man
);
   logic [MAN_W-1:0]        ent [NPH+1];
   logic [NPH:0][MAN_W-1:0] ent_view;
   logic [NPH:0]            we;

   for (genvar k = 0; k <= NPH; k++) begin : g_ent
      if (k == NPH) begin : g_sum
         assign we[k] = wr_commit & ch_hit & ph_sum;
      end else begin : g_ph
         assign we[k] = wr_commit & ch_hit & (ph_all | (phase_sel == 8'(k)));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     ent[k] <= RST_MAN;
         else if (we[k]) ent[k] <= wr_man;
      end

      assign ent_view[k] = ent[k];

      AST_ENTRY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
         gain_ok({GAIN_EXP, ent[k]}));                                   // R6
   end

   always_comb begin
      rd_man = '0;
      for (int k = 0; k <= NPH; k++)
         if (int'(rd_slot) == k) rd_man = ent[k];
   end

   AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_commit && ch_hit) |=> $stable(ent_view));                     // R7
   AST_SUM_APART: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit && !ph_sum) |=> $stable(ent_view[NPH]));               // R5
endmodule

// File: rtl/calgain_status.sv
module calgain_status (
   input  logic clk,
   input  logic rst_n,
   input  logic bad_access,
   input  logic clr_stb,
   output logic cml_err,
   output logic sw_cml,
   output logic alert
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cml_err <= 1'b0;
         sw_cml  <= 1'b0;
         alert   <= 1'b0;
      end else if (bad_access) begin
         cml_err <= 1'b1;
         sw_cml  <= 1'b1;
         alert   <= 1'b1;
      end else if (clr_stb) begin
         cml_err <= 1'b0;
         sw_cml  <= 1'b0;
         alert   <= 1'b0;
      end
   end

   AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |=> (cml_err && sw_cml && alert));                      // R7
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (alert && !clr_stb) |=> alert);                                   // R11
   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !bad_access) |=> !(cml_err || sw_cml || alert));       // R11
endmodule

// File: rtl/calgain_bank.sv
module calgain_bank
   import calgain_pkg::*;
#(
   parameter int          NPH_A    = 6,
   parameter int          NPH_B    = 2,
   parameter logic [15:0] RST_WORD = 16'hD140
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_hit,
   input  logic        wr_stb,
   input  logic        rd_stb,
   input  logic        word_acc,
   input  logic [7:0]  page_sel,
   input  logic [7:0]  phase_sel,
   input  logic [15:0] wr_word,
   input  logic        clr_stb,
   output logic [15:0] rd_word,
   output logic        rd_valid,
   output logic        cml_err,
   output logic        sw_cml,
   output logic        alert
);
   localparam int               MAXN    = (NPH_A > NPH_B) ? NPH_A : NPH_B;
   localparam int               SLOT_W  = $clog2(MAXN + 1);
   localparam logic [MAN_W-1:0] RST_MAN = RST_WORD[MAN_W-1:0];

   if (NPH_A < 1 || NPH_A > 127) begin : g_bad_a
      $error("NPH_A must lie in 1..127");
   end
   if (NPH_B < 1 || NPH_B > 127) begin : g_bad_b
      $error("NPH_B must lie in 1..127");
   end
   if (RST_WORD < GAIN_LO || RST_WORD > GAIN_HI) begin : g_bad_rst
      $error("RST_WORD outside legal gain window");
   end

   logic              wr_commit, hit_a, hit_b, ph_all, ph_sum;
   logic              rd_go, rd_ok, rd_ch, bad_access;
   logic [SLOT_W-1:0] rd_slot;
   logic [MAN_W-1:0]  man_a, man_b;

   calgain_decode #(.NPH_A(NPH_A), .NPH_B(NPH_B), .SLOT_W(SLOT_W)) i_dec (
      .cmd_hit(cmd_hit), .wr_stb(wr_stb), .rd_stb(rd_stb), .word_acc(word_acc),
      .page_sel(page_sel), .phase_sel(phase_sel), .wr_word(wr_word),
      .wr_commit(wr_commit), .hit_a(hit_a), .hit_b(hit_b), .ph_all(ph_all),
      .ph_sum(ph_sum), .rd_go(rd_go), .rd_ok(rd_ok), .rd_ch(rd_ch),
      .rd_slot(rd_slot), .bad_access(bad_access));

   calgain_store #(.NPH(NPH_A), .SLOT_W(SLOT_W), .RST_MAN(RST_MAN)) i_st_a (
      .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .ch_hit(hit_a),
      .ph_all(ph_all), .ph_sum(ph_sum), .phase_sel(phase_sel),
      .wr_man(wr_word[MAN_W-1:0]), .rd_slot(rd_slot), .rd_man(man_a));

   calgain_store #(.NPH(NPH_B), .SLOT_W(SLOT_W), .RST_MAN(RST_MAN)) i_st_b (
      .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .ch_hit(hit_b),
      .ph_all(ph_all), .ph_sum(ph_sum), .phase_sel(phase_sel),
      .wr_man(wr_word[MAN_W-1:0]), .rd_slot(rd_slot), .rd_man(man_b));

   calgain_status i_stat (
      .clk(clk), .rst_n(rst_n), .bad_access(bad_access), .clr_stb(clr_stb),
      .cml_err(cml_err), .sw_cml(sw_cml), .alert(alert));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_word  <= '0;
      end else begin
         rd_valid <= rd_go;
         if (rd_go)
            rd_word <= rd_ok ? {GAIN_EXP, (rd_ch ? man_b : man_a)} : '0;
      end
   end

   AST_RD_EXP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_word != 16'h0) |-> (rd_word[15:11] == GAIN_EXP));  // R6
   AST_RD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(cmd_hit && rd_stb));                            // R12
   AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && cmd_hit && !word_acc) |=> (rd_word == 16'h0));          // R8
endmodule

// File: tb/test_calgain_bank.sv
module test_calgain_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NA = 6;
   localparam int NB = 2;
   localparam int MX = (NA > NB) ? NA : NB;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_hit = 0, wr_stb = 0, rd_stb = 0, word_acc = 1, clr_stb = 0;
   logic [7:0]  page_sel = 0, phase_sel = 0;
   logic [15:0] wr_word = 0, rd_word;
   logic rd_valid, cml_err, sw_cml, alert;

   calgain_bank #(.NPH_A(NA), .NPH_B(NB), .RST_WORD(16'hD140)) i_calgain_bank (
      .clk(clk), .rst_n(rst_n), .cmd_hit(cmd_hit), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .word_acc(word_acc), .page_sel(page_sel), .phase_sel(phase_sel),
      .wr_word(wr_word), .clr_stb(clr_stb), .rd_word(rd_word), .rd_valid(rd_valid),
      .cml_err(cml_err), .sw_cml(sw_cml), .alert(alert));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   bit exp_err = 0;
   logic [10:0] ma [NA+1];
   logic [10:0] mb [NB+1];
   logic [15:0] exp_q [$];
   string       tag_q [$];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: scoreboard of read results
   always @(negedge clk) begin
      if (rst_n && rd_valid && !done) begin
         if (exp_q.size() == 0) check("R12 unexpected rd_valid", 1, 0);
         else check(tag_q.pop_front(), rd_word, exp_q.pop_front());
      end
   end

   function automatic bit pg_ok(logic [7:0] p);
      return p == 8'h00 || p == 8'h01 || p == 8'hFF;
   endfunction
   function automatic int lim(logic [7:0] p);
      return (p == 8'h00) ? NA : ((p == 8'h01) ? NB : MX);
   endfunction

   task automatic pulse(bit wr, logic [7:0] p, logic [7:0] ph, logic [15:0] w,
                        bit word, bit hit, bit clr);
      @(negedge clk);
      cmd_hit = hit; wr_stb = wr; rd_stb = !wr; word_acc = word;
      page_sel = p; phase_sel = ph; wr_word = w; clr_stb = clr;
      @(negedge clk);
      cmd_hit = 0; wr_stb = 0; rd_stb = 0; word_acc = 1; clr_stb = 0;
   endtask

   task automatic chk_flags(string tag);
      check(tag, {29'd0, cml_err, sw_cml, alert}, exp_err ? 32'd7 : 32'd0);
   endtask

   task automatic do_write(string tag, logic [7:0] p, logic [7:0] ph, logic [15:0] w,
                           bit word = 1, bit hit = 1, bit clr = 0);
      bit ok;
      ok = word && w >= 16'hD131 && w <= 16'hD150 && pg_ok(p) &&
           (ph == 8'hFF || ph == 8'h80 || (ph < 8'h80 && int'(ph) < lim(p)));
      pulse(1, p, ph, w, word, hit, clr);
      if (hit && ok) begin
         if (p == 8'h00 || p == 8'hFF) begin
            if (ph == 8'hFF) for (int k = 0; k < NA; k++) ma[k] = w[10:0];
            else if (ph == 8'h80) ma[NA] = w[10:0];
            else if (int'(ph) < NA) ma[ph] = w[10:0];
         end
         if (p == 8'h01 || p == 8'hFF) begin
            if (ph == 8'hFF) for (int k = 0; k < NB; k++) mb[k] = w[10:0];
            else if (ph == 8'h80) mb[NB] = w[10:0];
            else if (int'(ph) < NB) mb[ph] = w[10:0];
         end
      end
      if (hit && !ok) exp_err = 1;
      else if (clr) exp_err = 0;
      chk_flags({tag, " flags"});
   endtask

   task automatic do_read(string tag, logic [7:0] p, logic [7:0] ph,
                          bit word = 1, bit hit = 1);
      bit ok, dflt;
      logic [10:0] v;
      dflt = (p == 8'hFF) || (ph == 8'hFF);
      ok = word && pg_ok(p) &&
           (dflt || ph == 8'h80 || (ph < 8'h80 && int'(ph) < lim(p)));
      if (dflt) v = ma[0];
      else if (p == 8'h01) v = (ph == 8'h80) ? mb[NB] : mb[ph];
      else v = (ph == 8'h80) ? ma[NA] : ma[ph];
      if (hit) begin
         exp_q.push_back(ok ? {5'b11010, v} : 16'h0000);
         tag_q.push_back(tag);
      end
      pulse(0, p, ph, 16'h0, word, hit, 0);
      if (!hit) check({tag, " no rd_valid"}, rd_valid, 0);
      if (hit && !ok) exp_err = 1;
      chk_flags({tag, " flags"});
   endtask

   task automatic clear(string tag);
      pulse(1, 8'h0, 8'h0, 16'h0, 1, 0, 1);
      exp_err = 0;
      chk_flags(tag);
   endtask

   task automatic read_all(string tag);
      for (int k = 0; k < NA; k++) do_read(tag, 8'h00, 8'(k));
      do_read(tag, 8'h00, 8'h80);
      for (int k = 0; k < NB; k++) do_read(tag, 8'h01, 8'(k));
      do_read(tag, 8'h01, 8'h80);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k <= NA; k++) ma[k] = 11'h140;
      for (int k = 0; k <= NB; k++) mb[k] = 11'h140;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 reset flags", {cml_err, sw_cml, alert, rd_valid}, 0);
      read_all("R1 reset value");

      do_write("R2 write A ph3", 8'h00, 8'h02, 16'hD131);
      do_write("R2 write B ph2", 8'h01, 8'h01, 16'hD150);
      read_all("R2 selective");

      do_write("R3 both ch ph1", 8'hFF, 8'h00, 16'hD145);
      do_write("R3 both ch ph5", 8'hFF, 8'h04, 16'hD133);
      read_all("R3 page all");

      do_write("R4 all A phases", 8'h00, 8'hFF, 16'hD139);
      read_all("R4 phase all");
      do_write("R4 all phases both", 8'hFF, 8'hFF, 16'hD14E);
      read_all("R4 both all");

      do_write("R5 B total", 8'h01, 8'h80, 16'hD13A);
      do_write("R5 A total", 8'h00, 8'h80, 16'hD149);
      read_all("R5 totals");

      do_write("R7 below window", 8'h00, 8'h01, 16'hD130);
      clear("R11 clear after R7");
      do_write("R7 above window", 8'hFF, 8'hFF, 16'hD151);
      do_write("R7 bad exponent", 8'h00, 8'h80, 16'h5131);
      read_all("R7 unchanged");
      repeat (5) @(negedge clk);
      chk_flags("R11 sticky after idle");
      clear("R11 clear");

      do_write("R8 byte write", 8'h00, 8'h00, 16'hD140, 0);
      clear("R11 clear after R8 write");
      do_read("R8 byte read", 8'h00, 8'h00, 0);
      read_all("R8 unchanged");
      clear("R11 clear after R8 read");

      do_read("R9 page all read", 8'hFF, 8'h03);
      do_read("R9 phase all read", 8'h00, 8'hFF);
      do_read("R9 B phase all read", 8'h01, 8'hFF);

      do_read("R10 B phase beyond count", 8'h01, 8'h02);
      clear("R11 clear after R10");
      do_read("R10 bad page", 8'h02, 8'h00);
      clear("R11 clear after R10 page");
      do_write("R10 write beyond B", 8'h01, 8'h03, 16'hD140);
      do_write("R10 write beyond max", 8'hFF, 8'h06, 16'hD140);
      read_all("R10 unchanged");

      do_write("R11 clear with error", 8'h00, 8'h00, 16'h0000, 1, 1, 1);
      clear("R11 clear alone");

      do_write("R12 ignored write", 8'h00, 8'h00, 16'hD131, 1, 0);
      do_read("R12 ignored read", 8'h00, 8'h00, 1, 0);
      read_all("R12 unchanged");
      do_write("R6 low edge", 8'h00, 8'h05, 16'hD131);
      do_write("R6 high edge", 8'h01, 8'h00, 16'hD150);
      read_all("R6 edges");

      repeat (3) @(negedge clk);
      check("R2 scoreboard drained", exp_q.size(), 0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule